// File: doc/BRIEF.md
# Flat Panel Power Sequencer

This block drives the four switched rails of a flat panel interface: the logic supply, the data drivers, the bias supply and the final panel enable. A single request port asks for the panel to be brought up or taken down. The block then walks the rails one at a time, waiting a fixed number of clock cycles between steps. Bring-up runs logic, data, bias, enable. Take-down runs the same order reversed.

A request is written as a two-bit mode code. Only two codes start work: one asks for power-up and one asks for a full power-down. The other two codes are refused with a one-cycle reject pulse. A request that asks for the state the logic supply is already in is dropped. A request that arrives while a sequence is running is held in a one-deep slot and acted on once the running sequence has finished. If several requests arrive while the block is busy, the latest one replaces any earlier held request. The step spacing is the parameter `STEP_CYC`, counted in clock cycles. Its default corresponds to about 10 ms at 50 MHz.

Top module: `panel_pwr_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, all four rails, `busy`, `done` and `req_reject` are 0.
- R2: A power-up request (mode 2'b00) sampled at clock edge k, with the logic supply off, raises `vdd_on` at edge k+1. It raises `data_on` at k+1+S, `bias_on` at k+1+2S and `panel_on` at k+1+3S, where S = `STEP_CYC`.
- R3: A power-down request (mode 2'b01) sampled at edge k, with the logic supply on, lowers `panel_on` at edge k+1. It lowers `bias_on` at k+1+S, `data_on` at k+1+2S and `vdd_on` at k+1+3S.
- R4: Power-down holds one more settling period after the logic supply is removed. `busy` stays high until edge k+1+4S and `done` pulses there with no rail change.
- R5: Power-up has no trailing delay. `busy` falls and `done` pulses at the same edge where `panel_on` rises.
- R6: `done` is high for exactly one cycle per completed sequence and only when `busy` falls.
- R7: A request that asks for the state `vdd_on` already has does not set `busy`, does not pulse `done` and leaves every rail unchanged. This applies whether the request arrives while idle or is held until a sequence ends.
- R8: Mode codes 2'b10 and 2'b11 give a `req_reject` pulse one cycle after they are sampled. They change no rail and start no sequence.
- R9: A legal request sampled while a sequence is running is held. Its sequence starts at the edge right after the `done` pulse of the running one.
- R10: The rails only change one at a time. At any time they form an ordered prefix: enable implies bias, bias implies data, and data implies logic.
- R11: `busy` is high from the edge of the first step, which is one edge after the request is sampled, until the sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled each rising edge |
| req_mode | input | 2 | Request code: 00 up, 01 down, 10/11 refused |
| vdd_on | output | 1 | Panel logic supply enable |
| data_on | output | 1 | Panel data driver enable |
| bias_on | output | 1 | Panel bias supply enable |
| panel_on | output | 1 | Final panel enable |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |
| req_reject | output | 1 | One-cycle pulse for a refused mode code |

## Verification
The hardest case to reach is a request that lands while a sequence is still running. The block must hold it across the tail of that sequence and start the next one exactly one edge after `done`. The bench reaches this by starting a power-up and then injecting a power-down at every cycle offset of the up sequence, including the edge where `done` itself pulses. It checks the full rail, busy and done pattern of both sequences back to back against step arithmetic. A held request that matches the state at completion is also injected, to show it is dropped.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int RAIL_N = 4;

  typedef enum logic [1:0] {
    MODE_UP   = 2'b00,
    MODE_DOWN = 2'b01,
    MODE_RSV2 = 2'b10,
    MODE_RSV3 = 2'b11
  } psq_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } psq_state_e;

  // lowest n rails on, in bring-up order
  function automatic logic [RAIL_N-1:0] rail_prefix(input int n);
    logic [RAIL_N-1:0] v;
    for (int i = 0; i < RAIL_N; i++) v[i] = (i < n);
    return v;
  endfunction
endpackage

// File: rtl/psq_req.sv
module psq_req
  import psq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic       take,
  output logic       pend_valid,
  output logic       pend_up,
  output logic       reject
);
  logic legal;
  assign legal = (req_mode == MODE_UP) || (req_mode == MODE_DOWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_up    <= 1'b0;
      reject     <= 1'b0;
    end else begin
      reject <= req_valid && !legal;
      if (req_valid && legal) begin
        pend_valid <= 1'b1;
        pend_up    <= (req_mode == MODE_UP);
      end else if (take) begin
        pend_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/psq_timer.sv
module psq_timer #(
  parameter int STEP_CYC = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(STEP_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= RELOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/psq_fsm.sv
module psq_fsm
  import psq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pend_valid,
  input  logic              pend_up,
  input  logic              expired,
  output logic              take,
  output logic              load,
  output logic [RAIL_N-1:0] rail,
  output logic              busy,
  output logic              done
);
  localparam int IW = $clog2(RAIL_N);
  localparam logic [IW-1:0] LAST_IDX = IW'(RAIL_N - 1);
  localparam logic [IW-1:0] PRE_LAST = IW'(RAIL_N - 2);

  psq_state_e state;
  logic          dir_up;
  logic [IW-1:0] idx;
  logic          start, finish, advance;

  always_comb begin
    take    = (state == ST_IDLE) && pend_valid;
    start   = take && (pend_up != rail[0]);
    finish  = (state == ST_RUN) && expired &&
              ((dir_up && idx == PRE_LAST) || (!dir_up && idx == LAST_IDX));
    advance = (state == ST_RUN) && expired && !finish;
    load    = start || advance;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      dir_up <= 1'b0;
      idx    <= '0;
      rail   <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state  <= ST_RUN;
        dir_up <= pend_up;
        idx    <= '0;
        busy   <= 1'b1;
        rail   <= pend_up ? rail_prefix(1) : rail_prefix(RAIL_N - 1);
      end else if (advance) begin
        idx  <= idx + 1'b1;
        rail <= dir_up ? rail_prefix(int'(idx) + 2)
                       : rail_prefix(RAIL_N - 2 - int'(idx));
      end else if (finish) begin
        state <= ST_IDLE;
        busy  <= 1'b0;
        done  <= 1'b1;
        if (dir_up) rail <= rail_prefix(RAIL_N);
      end
    end
  end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import psq_pkg::*;
#(
  parameter int STEP_CYC = 500000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  output logic       vdd_on,
  output logic       data_on,
  output logic       bias_on,
  output logic       panel_on,
  output logic       busy,
  output logic       done,
  output logic       req_reject
);
  logic              pend_valid, pend_up, take, load, expired;
  logic [RAIL_N-1:0] rail;

  psq_req u_req (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .take(take), .pend_valid(pend_valid), .pend_up(pend_up),
    .reject(req_reject)
  );

  psq_timer #(.STEP_CYC(STEP_CYC)) u_tmr (
    .clk(clk), .rst(rst), .load(load), .expired(expired)
  );

  psq_fsm u_fsm (
    .clk(clk), .rst(rst), .pend_valid(pend_valid), .pend_up(pend_up),
    .expired(expired), .take(take), .load(load), .rail(rail),
    .busy(busy), .done(done)
  );

  assign vdd_on   = rail[0];
  assign data_on  = rail[1];
  assign bias_on  = rail[2];
  assign panel_on = rail[3];
endmodule

// File: rtl/psq_chk.sv
module psq_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] rail,
  input logic       busy,
  input logic       done
);
  AST_RAIL_PREFIX: assert property (@(posedge clk) disable iff (rst)
    (rail == 4'h0 || rail == 4'h1 || rail == 4'h3 || rail == 4'h7 || rail == 4'hF)); // R10
  AST_ONE_RAIL: assert property (@(posedge clk) disable iff (rst)
    (rail != $past(rail)) |-> ($countones(rail ^ $past(rail)) == 1)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> $stable(rail)); // R7
  AST_UP_NO_TAIL: assert property (@(posedge clk) disable iff (rst)
    (done && rail[3]) |-> $rose(rail[3])); // R5
  AST_DOWN_TAIL: assert property (@(posedge clk) disable iff (rst)
    (done && !rail[0]) |-> $stable(rail)); // R4
endmodule

bind panel_pwr_seq psq_chk u_chk (
  .clk(clk), .rst(rst),
  .rail({panel_on, bias_on, data_on, vdd_on}),
  .busy(busy), .done(done)
);

// File: tb/sim_panel_pwr_seq.sv
module sim_panel_pwr_seq;
  localparam int S = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic vdd_on, data_on, bias_on, panel_on, busy, done, req_reject;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  panel_pwr_seq #(.STEP_CYC(S)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .vdd_on(vdd_on), .data_on(data_on), .bias_on(bias_on), .panel_on(panel_on),
    .busy(busy), .done(done), .req_reject(req_reject)
  );

  function automatic logic [3:0] pre(input int n);
    return 4'((1 << n) - 1);
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // {rail[3:0], busy, done, reject}
  function automatic logic [6:0] obs();
    return {panel_on, bias_on, data_on, vdd_on, busy, done, req_reject};
  endfunction

  // issue one request; returns at the negedge after the sampling edge
  task automatic req(input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1;
    req_mode  = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // follow a sequence whose first step lands on the next edge
  task automatic trace(input bit up, input int inj, input logic [1:0] im, input string rq);
    int n;
    n = up ? 3 * S : 4 * S;
    for (int j = 0; j <= n; j++) begin
      logic [3:0] er;
      logic [6:0] e;
      @(negedge clk);
      if (j == inj + 1) req_valid = 1'b0;
      if (up) er = pre((j / S + 1 > 4) ? 4 : j / S + 1);
      else    er = pre(3 - ((j / S > 3) ? 3 : j / S));
      e = {er, 1'(j < n), 1'(j == n), 1'b0};
      chk(obs() == e, rq, obs(), e);
      if (j == inj) begin
        req_valid = 1'b1;
        req_mode  = im;
      end
    end
  endtask

  task automatic quiet(input int cyc, input logic [3:0] er, input string rq);
    for (int j = 0; j < cyc; j++) begin
      @(negedge clk);
      chk(obs() == {er, 3'b000}, rq, obs(), {er, 3'b000});
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(obs() == 7'd0, "R1 in reset", obs(), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(obs() == 7'd0, "R1 after reset", obs(), 0);

    // power-up from off
    req(2'b00);
    chk(busy == 1'b0, "R11 not busy at capture", busy, 0);
    trace(1'b1, -1, 2'b00, "R2 R5 R6 R11 up");
    // same-state request ignored
    req(2'b00);
    quiet(4 * S, 4'hF, "R7 up while up");
    // refused codes, from on state
    for (int m = 2; m < 4; m++) begin
      req(2'(m));
      chk(obs() == {4'hF, 3'b001}, "R8 reject pulse", obs(), {4'hF, 3'b001});
      quiet(2 * S, 4'hF, "R8 refused code no effect");
    end
    // power-down
    req(2'b01);
    trace(1'b0, -1, 2'b00, "R3 R4 R6 down");
    req(2'b01);
    quiet(4 * S, 4'h0, "R7 down while down");
    req(2'b11);
    chk(obs() == 7'b0000001, "R8 reject from off", obs(), 1);
    quiet(2 * S, 4'h0, "R8 refused code from off");

    // R9: down request injected at every offset of an up sequence
    for (int o = 0; o < 3 * S; o++) begin
      req(2'b00);
      trace(1'b1, o, 2'b01, "R9 up with held down");
      trace(1'b0, -1, 2'b00, "R9 held down serviced");
    end
    // held request that matches at completion is dropped
    req(2'b00);
    trace(1'b1, 2, 2'b00, "R7 held matching up");
    quiet(3 * S, 4'hF, "R7 held matching up dropped");
    req(2'b01);
    trace(1'b0, S, 2'b01, "R7 held matching down");
    quiet(3 * S, 4'h0, "R7 held matching down dropped");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule